// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a single-port synchronous static RAM built so that reads and writes can alternate every cycle with no idle cycle between them. The block samples command, address and byte enables on each rising clock edge. Write data follows its address by the same number of cycles that read data follows a read address. Because of this, the shared data bus is never handed back and forth in mid-sequence. A static mode input picks a registered-output (pipelined) variant or a combinational-output (flow-through) variant. A static order input picks how four-beat bursts walk through the two low address bits.

Each pending write's address and byte enables wait in a short command pipeline until their data arrives. If a read hits a location whose write is still waiting, it returns the new bytes merged over the array contents. An asynchronous output enable and a sleep input gate the output drive. Sleep also stops new commands from being accepted. The data interfaces have no valid/ready pair. Latency is fixed, and the bus cannot apply back-pressure. A caller must present write data in the cycle the latency rule dictates and must take read data when `rvalid` is high.

Top module: `lw_sram`

## Requirements
- R1: While reset is low, and in the first cycle after it, `rvalid` and `rdata_oe` are 0.
- R2: A command is taken only when `ce_a`, `ce_b` and `ce_c` are all 1. Otherwise it causes no read result and no write.
- R3: With `flow_mode`=0, a read taken at clock edge t produces `rvalid`=1 and its data in the cycle after edge t+1, which is sampled at edge t+2.
- R4: With `flow_mode`=1, a read taken at edge t produces `rvalid`=1 and its data in the cycle after edge t, which is sampled at edge t+1.
- R5: Write data is sampled from `wdata` two edges after its address with `flow_mode`=0, and one edge after it with `flow_mode`=1.
- R6: Lane i of the data word is bits [9i+8:9i]. Lane i is written only when `be[i]`=1. All other lanes keep their stored value.
- R7: Reads and writes may alternate on consecutive cycles with no idle cycle, and every read returns correct data.
- R8: A read of an address whose write data has not yet been committed returns the enabled bytes of that write merged over the stored bytes.
- R9: With `burst_order`=0 and `adv`=1, each beat uses the burst start address with its two low bits replaced by (start + k) mod 4 for beat k = 1, 2, 3, and then wraps.
- R10: With `burst_order`=1, beat k uses the low two bits start XOR k.
- R11: A cycle with `adv`=1 continues the direction of the burst start and ignores `we`. Each write beat takes its own `be`.
- R12: `rdata_oe` is 1 only while `out_en`=1, `sleep`=0 and `rvalid`=1. It follows `out_en` and `sleep` without waiting for a clock edge.
- R13: While `sleep`=1, commands are ignored and stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_mode | input | 1 | Static: 0 = pipelined (registered output), 1 = flow-through |
| burst_order | input | 1 | Static: 0 = linear, 1 = interleaved |
| sleep | input | 1 | Power-down: blocks commands and output drive |
| out_en | input | 1 | Asynchronous output enable, active high |
| ce_a | input | 1 | Chip enable A, active high |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c | input | 1 | Chip enable C, active high |
| adv | input | 1 | 1 = next burst beat, 0 = new access from `addr` |
| we | input | 1 | 1 = write, 0 = read (only when `adv`=0) |
| addr | input | ADDR_W | Start address |
| be | input | BYTES | Per-lane write enables |
| wdata | input | BYTES*BYTE_W | Late write data |
| rdata | output | BYTES*BYTE_W | Read data |
| rvalid | output | 1 | Read data is present on `rdata` |
| rdata_oe | output | 1 | Output drive enable |

## Verification
The bench writes partial bytes to an address and reads that same address on the very next cycle in pipelined mode. A design without forwarding would return the stale word, and a design that forwarded the whole word would return garbage in the lane that was not enabled. It runs write bursts with `we` held low on the advance beats, and read bursts from a start address whose linear and interleaved walks differ. A design that took `we` on advance beats, or that mixed up the two orders, would miss the queued expected values. Sleep and deselection are applied while reads are in flight and while new commands arrive. A leaky design would produce unexpected read results or overwrite data, and a design whose output drive ignores `sleep` or `out_en` would be caught at the port.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  // Low two address bits for beat number `beat` of a burst started at `base`.
  function automatic logic [1:0] beat_lsb(burst_order_e ord, logic [1:0] base, logic [1:0] beat);
    return (ord == ORD_XOR) ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/lw_burst_gen.sv
module lw_burst_gen
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_we,
  input  burst_order_e      order,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_we
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              dir_q;
  logic [1:0]        beat_nx;

  assign beat_nx = beat_q + 2'd1;

  // R9 R10 R11: beats reuse the stored direction and the stored start address
  always_comb begin
    if (start) begin
      cur_addr = start_addr;
      cur_we   = start_we;
    end else begin
      cur_addr = {base_q[ADDR_W-1:2], beat_lsb(order, base_q[1:0], beat_nx)};
      cur_we   = dir_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      dir_q  <= 1'b0;
    end else if (start) begin
      base_q <= start_addr;
      beat_q <= '0;
      dir_q  <= start_we;
    end else if (advance) begin
      beat_q <= beat_nx;
    end
  end

endmodule

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic                           in_we,
  input  logic [ADDR_W-1:0]              in_addr,
  input  logic [BYTES-1:0]               in_be,
  output logic [STAGES-1:0]              v_q,
  output logic [STAGES-1:0]              we_q,
  output logic [STAGES-1:0][ADDR_W-1:0]  addr_q,
  output logic [STAGES-1:0][BYTES-1:0]   be_q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic              v_d;
    logic              we_d;
    logic [ADDR_W-1:0] addr_d;
    logic [BYTES-1:0]  be_d;

    if (s == 0) begin : g_head
      assign v_d    = in_valid;
      assign we_d   = in_we;
      assign addr_d = in_addr;
      assign be_d   = in_be;
    end else begin : g_tail
      assign v_d    = v_q[s-1];
      assign we_d   = we_q[s-1];
      assign addr_d = addr_q[s-1];
      assign be_d   = be_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s]    <= 1'b0;
        we_q[s]   <= 1'b0;
        addr_q[s] <= '0;
        be_q[s]   <= '0;
      end else begin
        v_q[s]    <= v_d;
        we_q[s]   <= we_d;
        addr_q[s] <= addr_d;
        be_q[s]   <= be_d;
      end
    end
  end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTES-1:0]        wr_be,
  input  logic [BYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTES*BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // R6: one storage column per byte lane
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) cells[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    burst_order,
  input  logic                    sleep,
  input  logic                    out_en,
  input  logic                    ce_a,
  input  logic                    ce_b,
  input  logic                    ce_c,
  input  logic                    adv,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES-1:0]        be,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] rdata,
  output logic                    rvalid,
  output logic                    rdata_oe
);

  localparam int DATA_W = BYTES * BYTE_W;
  localparam int STAGES = 2;

  // R2 R13: all three enables and no sleep
  logic take;
  assign take = ce_a & ce_b & ce_c & ~sleep;

  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;

  lw_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take & ~adv),
    .advance    (take & adv),
    .start_addr (addr),
    .start_we   (we),
    .order      (burst_order_e'(burst_order)),
    .cur_addr   (cur_addr),
    .cur_we     (cur_we)
  );

  logic [STAGES-1:0]             st_v;
  logic [STAGES-1:0]             st_we;
  logic [STAGES-1:0][ADDR_W-1:0] st_addr;
  logic [STAGES-1:0][BYTES-1:0]  st_be;

  lw_cmd_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES), .STAGES(STAGES)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (take),
    .in_we    (cur_we),
    .in_addr  (cur_addr),
    .in_be    (be),
    .v_q      (st_v),
    .we_q     (st_we),
    .addr_q   (st_addr),
    .be_q     (st_be)
  );

  // R5: commit stage is one deep for flow-through, two deep when pipelined
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTES-1:0]  wr_be;

  always_comb begin
    if (flow_mode) begin
      wr_en   = st_v[0] & st_we[0];
      wr_addr = st_addr[0];
      wr_be   = st_be[0];
    end else begin
      wr_en   = st_v[1] & st_we[1];
      wr_addr = st_addr[1];
      wr_be   = st_be[1];
    end
  end

  logic [DATA_W-1:0] arr_q;

  lw_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_be   (wr_be),
    .wr_data (wdata),
    .rd_addr (st_addr[0]),
    .rd_data (arr_q)
  );

  // R8: a pipelined read overlaps the commit of the write one slot older
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_word;

  assign fwd_hit = st_v[1] & st_we[1] & (st_addr[1] == st_addr[0]);

  for (genvar g = 0; g < BYTES; g++) begin : g_fwd
    assign fwd_word[g*BYTE_W +: BYTE_W] = (fwd_hit && st_be[1][g]) ?
                                          wdata[g*BYTE_W +: BYTE_W] :
                                          arr_q[g*BYTE_W +: BYTE_W];
  end

  logic              rd_now;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign rd_now = st_v[0] & ~st_we[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_now;
      if (rd_now) rdata_q <= fwd_word;
    end
  end

  // R3 R4: output register present only in pipelined mode
  assign rvalid = flow_mode ? rd_now : rvalid_q;
  assign rdata  = flow_mode ? arr_q : rdata_q;

  // R12: asynchronous drive gating
  assign rdata_oe = out_en & ~sleep & rvalid;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic flow_mode,
  input logic sleep,
  input logic out_en,
  input logic sel_all,
  input logic adv,
  input logic we,
  input logic rvalid,
  input logic rdata_oe
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rvalid);

  // R2
  desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && !sel_all) |=> !rvalid);

  // R2
  desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && !sel_all) |-> ##2 !rvalid);

  // R3
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && sel_all && !sleep && !adv && !we) |-> ##2 rvalid);

  // R4
  flow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && sel_all && !sleep && !adv && !we) |=> rvalid);

  // R12
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en || sleep) |-> !rdata_oe);

  // R13
  sleep_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && sleep) |=> !rvalid);

  // R13
  sleep_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && sleep) |-> ##2 !rvalid);

endmodule

bind lw_sram lw_sram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flow_mode (flow_mode),
  .sleep     (sleep),
  .out_en    (out_en),
  .sel_all   (ce_a & ce_b & ce_c),
  .adv       (adv),
  .we        (we),
  .rvalid    (rvalid),
  .rdata_oe  (rdata_oe)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic flow = 1'b0, ilv = 1'b0, slp = 1'b0, oen = 1'b1;
  logic cea = 1'b0, ceb = 1'b0, cec = 1'b0, adv = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] be = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, rdata_oe;

  lw_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow), .burst_order(ilv), .sleep(slp),
    .out_en(oen), .ce_a(cea), .ce_b(ceb), .ce_c(cec), .adv(adv), .we(we),
    .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .rdata_oe(rdata_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [DW-1:0] data;
    int            due;
    string         tag;
  } exp_t;
  exp_t expq[$];

  logic [DW-1:0] model [256];
  logic [DW-1:0] wq1 = '0, wq2 = '0;
  int  bbase = 0, bbeat = 0;
  bit  bwe = 0;
  logic nx_slp = 1'b0, nx_oe = 1'b1;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NB; i++) if (m[i]) r[i*BW +: BW] = nw[i*BW +: BW];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: one command per clock edge; keeps the late-data pipe and model.
  task automatic cmd(logic [2:0] m, bit w, bit a, int ad, logic [NB-1:0] b,
                     logic [DW-1:0] d, string tag);
    bit take, ew;
    int ea, lo;
    @(negedge clk);
    cea = m[0]; ceb = m[1]; cec = m[2];
    we = w; adv = a; addr = AW'(ad); be = b;
    slp = nx_slp; oen = nx_oe;
    wdata = flow ? wq1 : wq2;   // R5
    take = (&m) && !nx_slp;
    ea = 0; ew = 0;
    if (take) begin
      if (!a) begin
        bbase = ad; bbeat = 0; bwe = w; ea = ad; ew = w;
      end else begin
        bbeat = (bbeat + 1) % 4;
        lo = ilv ? ((bbase & 3) ^ bbeat) : (((bbase & 3) + bbeat) & 3);
        ea = (bbase & ~3) | lo; ew = bwe;
      end
    end
    wq2 = wq1;
    wq1 = (take && ew) ? d : '0;
    if (take && ew) model[ea] = merge(model[ea], d, b);
    if (take && !ew) expq.push_back('{model[ea], cyc + 1 + (flow ? 0 : 1), tag});
  endtask

  // Scoreboard monitor, sampled mid-cycle after the rising edge
  always begin
    @(posedge clk);
    #3;
    if (rst_n && !done) begin
      if (rvalid) begin
        if (expq.size() == 0) begin
          check(0, "R2/R13 unexpected read", rdata, '0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(rdata === e.data && cyc == e.due, e.tag, rdata, e.data);
          // R12
          check(rdata_oe === (oen && !slp), "R12 drive", DW'(rdata_oe), DW'(oen && !slp));
        end
      end else if (expq.size() != 0 && expq[0].due <= cyc) begin
        exp_t e;
        e = expq.pop_front();
        check(0, {e.tag, " missing read"}, 'x, e.data);
      end
    end
  end

  task automatic do_reset(bit f, bit o);
    @(negedge clk);
    rst_n = 0; cea = 0; ceb = 0; cec = 0; adv = 0; we = 0;
    flow = f; ilv = o; nx_slp = 0; nx_oe = 1; slp = 0; oen = 1;
    wq1 = '0; wq2 = '0; bbase = 0; bbeat = 0; bwe = 0;
    repeat (3) @(negedge clk);
    @(posedge clk); #3;
    // R1
    check(rvalid === 1'b0 && rdata_oe === 1'b0, "R1 reset", DW'({rvalid, rdata_oe}), '0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #3;
    check(rvalid === 1'b0, "R1 after release", DW'(rvalid), '0);
  endtask

  task automatic phase(bit f, bit o, int ph);
    do_reset(f, o);
    for (int i = 0; i < 16; i++) cmd(3'b111, 1, 0, i, 2'b11, DW'(i * 37 + ph * 101 + 5), "R5");
    for (int i = 0; i < 16; i++) cmd(3'b111, 0, 0, i, 2'b11, '0, f ? "R4" : "R3");
    // R7: alternate write/read every cycle
    for (int i = 0; i < 8; i++) begin
      cmd(3'b111, 1, 0, i, 2'b11, DW'(i * 53 + ph * 7 + 1), "R7");
      cmd(3'b111, 0, 0, (i + 4) % 16, 2'b11, '0, "R7");
    end
    // R8 R6: read right behind a partial write to the same address
    cmd(3'b111, 1, 0, 2, 2'b01, 18'h2_A5A5, "R6");
    cmd(3'b111, 0, 0, 2, 2'b11, '0, "R8");
    cmd(3'b111, 1, 0, 2, 2'b10, 18'h1_5A5A, "R6");
    cmd(3'b111, 0, 0, 2, 2'b11, '0, "R8");
    cmd(3'b111, 1, 0, 2, 2'b00, 18'h3_FFFF, "R6");
    cmd(3'b111, 0, 0, 2, 2'b11, '0, "R6");
    // R2: each enable low blocks the command
    cmd(3'b101, 1, 0, 9, 2'b11, 18'h0_0BAD, "R2");
    cmd(3'b011, 0, 0, 9, 2'b11, '0, "R2");
    cmd(3'b110, 1, 0, 9, 2'b11, 18'h0_0BEE, "R2");
    cmd(3'b111, 0, 0, 9, 2'b11, '0, "R2");
    // R11: write burst with we low on beats
    cmd(3'b111, 1, 0, 12, 2'b11, 18'h1_1111, "R11");
    cmd(3'b111, 0, 1, 0, 2'b01, 18'h2_2222, "R11");
    cmd(3'b111, 0, 1, 0, 2'b10, 18'h3_3333, "R11");
    cmd(3'b111, 0, 1, 0, 2'b11, 18'h0_4444, "R11");
    for (int i = 12; i < 16; i++) cmd(3'b111, 0, 0, i, 2'b11, '0, "R11");
    // R9 R10: read burst with we high on beats (ignored)
    cmd(3'b111, 0, 0, 5, 2'b11, '0, o ? "R10" : "R9");
    for (int k = 1; k < 5; k++) cmd(3'b111, 1, 1, 0, 2'b11, '0, o ? "R10" : "R9");
    // R12: output enable low during a read
    nx_oe = 0;
    cmd(3'b111, 0, 0, 1, 2'b11, '0, "R12");
    cmd(3'b000, 0, 0, 0, 2'b00, '0, "R12");
    cmd(3'b000, 0, 0, 0, 2'b00, '0, "R12");
    nx_oe = 1;
    // R13: sleep while a read is in flight and while commands arrive
    cmd(3'b111, 0, 0, 3, 2'b11, '0, "R13");
    nx_slp = 1;
    cmd(3'b111, 1, 0, 3, 2'b11, 18'h3_FFFF, "R13");
    cmd(3'b111, 0, 0, 3, 2'b11, '0, "R13");
    cmd(3'b111, 1, 1, 3, 2'b11, 18'h3_FFFF, "R13");
    nx_slp = 0;
    cmd(3'b111, 0, 0, 3, 2'b11, '0, "R13");
    for (int i = 0; i < 4; i++) cmd(3'b000, 0, 0, 0, 2'b00, '0, "drain");
    repeat (3) @(negedge clk);
    if (expq.size() != 0) begin
      check(0, "R3/R4 pending reads", DW'(expq.size()), '0);
      expq.delete();
    end
  endtask

  initial begin
    phase(0, 0, 0);
    phase(1, 1, 1);
    phase(0, 1, 2);
    phase(1, 0, 3);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule